// File: doc/BRIEF.md
# Ethernet PHY Port Manager

This block brings up an external Ethernet PHY and supervises it over the MII management interface without any help from software. It reads a small set of strap-style configuration inputs. From those inputs it picks one of two paths. On the forced path it programs a fixed speed and duplex into the PHY. On the other path it starts auto-negotiation and then resolves the common mode from the local advertisement and the link partner's abilities. It reports the outcome as a 2-bit mode with link and failure flags.

Management traffic goes through a request/acknowledge port to an MDIO master that lives outside this block. Once a link is up, the manager reads the PHY status on a fixed period. When the link drops, it raises an event and runs the whole bring-up sequence again. It steps back to idle whenever software takes over. The poll period and the link timeout are counted in prescaled ticks, so a simulation can shorten them.

Top module: `phy_port_mgr`

## Requirements
- R1: The manager is active only while `auto_sel_en`=1 and `sw_override`=0. While it is inactive, it starts no management transaction. A request already in flight is allowed to complete first.
- R2: Configuration starts from idle only when `phy_present`=1 and the PHY address has been captured.
- R3: The first `cfg_load_done` pulse copies `cfg_phy_addr` into a shadow register and sets `addr_valid`. Every later request carries the shadowed address on `mdio_phy`, even if `cfg_phy_addr` changes afterwards.
- R4: Each request holds `mdio_req`, `mdio_wr`, `mdio_reg` and `mdio_wdata` steady until `mdio_ack`. Registers used: 0 is control, 1 is status (bit 3 = able to auto-negotiate, bit 2 = link), 4 is the local advertisement, 5 is the partner abilities. Status is always read twice, and only the second value is acted on, because the link bit latches low.
- R5: The forced path is taken when status bit 3 is 0 or `force_an_en` is 0. On this path the manager writes register 0 with bit 13 = `force_100`, bit 8 = `force_fdx` and bit 12 = 0. Once link is seen, it reports mode {`force_100`,`force_fdx`}.
- R6: On the auto-negotiation path the manager writes 16'h1200 to register 0. Once link is seen, it reads registers 4 and 5 and ANDs bits [9:5] of the two values. It then picks by priority: bit 8 (100 full) gives mode 11, then bit 9 (100BASE-T4) gives 10, then bit 7 (100 half) gives 10, then bit 6 (10 full) gives 01, then bit 5 (10 half) gives 00.
- R7: If the two sides share no ability bit, the result is `link_up`=0, `link_fail`=1 and mode 00.
- R8: If link is not seen within LINK_TO_TICKS×TICK_DIV cycles after the control write, the result is `link_up`=0, `link_fail`=1 and mode 00.
- R9: While a link is up, the status register is read as a pair every POLL_TICKS×TICK_DIV cycles. A latched-low first read followed by a good second read leaves the link up.
- R10: If the second poll read shows no link, `link_down_evt` pulses for one cycle, the result becomes 0/0/00, and configuration restarts. After a failure, configuration is retried every poll period.
- R11: `res_upd` pulses for one cycle exactly when {`link_up`,`link_fail`,`res_mode`} changes. `link_up` and `link_fail` are never both 1. Mode encoding: bit 1 = 100 Mb/s, bit 0 = full duplex. All result outputs are 0 after reset.
- R12: The only register the manager ever writes is register 0. It never starts a next-page exchange.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| auto_sel_en | input | 1 | Automatic port selection enable |
| sw_override | input | 1 | Software has taken control |
| phy_present | input | 1 | External PHY detected |
| cfg_load_done | input | 1 | Configuration load finished (capture strobe) |
| cfg_phy_addr | input | 5 | Configured PHY address |
| force_an_en | input | 1 | Allow auto-negotiation |
| force_100 | input | 1 | Forced speed, 1 = 100 Mb/s |
| force_fdx | input | 1 | Forced duplex, 1 = full |
| mdio_req | output | 1 | Management request |
| mdio_wr | output | 1 | 1 = write, 0 = read |
| mdio_phy | output | 5 | PHY address of request |
| mdio_reg | output | 5 | Register number |
| mdio_wdata | output | 16 | Write data |
| mdio_ack | input | 1 | Request completed |
| mdio_rdata | input | 16 | Read data, valid with ack |
| addr_valid | output | 1 | Shadow address captured |
| res_mode | output | 2 | Resolved mode {100M, full duplex} |
| link_up | output | 1 | Link established |
| link_fail | output | 1 | Link could not be established |
| res_upd | output | 1 | Result changed this cycle |
| link_down_evt | output | 1 | Poll found the link dropped |

## Verification
The checker verifies the following on every cycle:
- no new request starts while the manager is inactive;
- requests appear only with a captured and frozen address, and hold steady until acknowledged;
- writes go only to the control register;
- up and fail are exclusive;
- a down event coincides with a cleared result, and an update pulse marks a real change.

Some behaviour can only be shown by the bench's scenarios, run against a PHY model whose link bit latches low. These cover the priority resolution across several ability sets, the forced control word, the no-common-mode failure, the timeout length and the poll period. They also cover surviving a latched-low glitch and restarting after a drop.

// File: rtl/ppm_pkg.sv
package ppm_pkg;

    localparam int ADDR_W = 5;
    localparam int DATA_W = 16;
    localparam int ABIL_W = 5;
    localparam int ABIL_LO = 5;
    localparam int ABIL_HI = ABIL_LO + ABIL_W - 1;

    localparam logic [ADDR_W-1:0] REG_CTRL = 5'd0;
    localparam logic [ADDR_W-1:0] REG_STAT = 5'd1;
    localparam logic [ADDR_W-1:0] REG_ADV  = 5'd4;
    localparam logic [ADDR_W-1:0] REG_LPA  = 5'd5;

    localparam int STAT_LINK   = 2;
    localparam int STAT_ANABLE = 3;
    localparam int CTRL_SPEED  = 13;
    localparam int CTRL_ANEN   = 12;
    localparam int CTRL_ANRST  = 9;
    localparam int CTRL_DUPLEX = 8;

    typedef enum logic [3:0] {
        S_IDLE, S_ST_A, S_ST_B, S_WR_CTRL, S_LNK_A, S_LNK_B,
        S_RD_ADV, S_RD_LPA, S_MON_WAIT, S_MON_A, S_MON_B, S_FAIL_WAIT
    } mgr_state_e;

    typedef struct packed {
        logic       up;
        logic       fail;
        logic [1:0] mode;
    } link_res_t;

    typedef struct packed {
        logic              wr;
        logic [ADDR_W-1:0] regad;
        logic [DATA_W-1:0] wdata;
    } mdio_cmd_t;

    // common: [4]=T4 [3]=100 full [2]=100 half [1]=10 full [0]=10 half
    function automatic logic [2:0] resolve_mode(input logic [ABIL_W-1:0] common);
        if (common[3])      return 3'b1_11;
        else if (common[4]) return 3'b1_10;
        else if (common[2]) return 3'b1_10;
        else if (common[1]) return 3'b1_01;
        else if (common[0]) return 3'b1_00;
        else                return 3'b0_00;
    endfunction

    function automatic logic [DATA_W-1:0] ctrl_word(input logic an, input logic spd,
                                                    input logic fdx);
        logic [DATA_W-1:0] v;
        v = '0;
        if (an) begin
            v[CTRL_ANEN]  = 1'b1;
            v[CTRL_ANRST] = 1'b1;
        end else begin
            v[CTRL_SPEED]  = spd;
            v[CTRL_DUPLEX] = fdx;
        end
        return v;
    endfunction

endpackage

// File: rtl/ppm_addr_shadow.sv
module ppm_addr_shadow #(
    parameter int AW = 5
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          load_done,
    input  logic [AW-1:0] addr_in,
    output logic [AW-1:0] addr_q,
    output logic          valid
);
    always_ff @(posedge clk) begin
        if (rst) begin
            addr_q <= '0;
            valid  <= 1'b0;
        end else if (load_done && !valid) begin
            addr_q <= addr_in;
            valid  <= 1'b1;
        end
    end
endmodule

// File: rtl/ppm_tick_timer.sv
module ppm_tick_timer #(
    parameter int TICK_DIV = 100000,
    parameter int CNT_W    = 12
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             clr,
    input  logic [CNT_W-1:0] limit,
    output logic             expired
);
    localparam int PRE_W = (TICK_DIV > 1) ? $clog2(TICK_DIV) : 1;
    localparam logic [PRE_W-1:0] PRE_LAST = PRE_W'(TICK_DIV - 1);

    logic [PRE_W-1:0] pre;
    logic [CNT_W-1:0] ticks;

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            pre   <= '0;
            ticks <= '0;
        end else if (ticks < limit) begin
            if (pre == PRE_LAST) begin
                pre   <= '0;
                ticks <= ticks + 1'b1;
            end else begin
                pre <= pre + 1'b1;
            end
        end
    end

    assign expired = (ticks >= limit);
endmodule

// File: rtl/ppm_resolver.sv
module ppm_resolver
    import ppm_pkg::*;
(
    input  logic [ABIL_W-1:0] adv_abil,
    input  logic [ABIL_W-1:0] lpa_abil,
    output logic              ok,
    output logic [1:0]        mode
);
    logic [2:0] pick;
    always_comb begin
        pick = resolve_mode(adv_abil & lpa_abil);
        ok   = pick[2];
        mode = pick[1:0];
    end
endmodule

// File: rtl/phy_port_mgr.sv
module phy_port_mgr
    import ppm_pkg::*;
#(
    parameter int TICK_DIV      = 100000,
    parameter int POLL_TICKS    = 900,
    parameter int LINK_TO_TICKS = 3000
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              auto_sel_en,
    input  logic              sw_override,
    input  logic              phy_present,
    input  logic              cfg_load_done,
    input  logic [ADDR_W-1:0] cfg_phy_addr,
    input  logic              force_an_en,
    input  logic              force_100,
    input  logic              force_fdx,
    output logic              mdio_req,
    output logic              mdio_wr,
    output logic [ADDR_W-1:0] mdio_phy,
    output logic [ADDR_W-1:0] mdio_reg,
    output logic [DATA_W-1:0] mdio_wdata,
    input  logic              mdio_ack,
    input  logic [DATA_W-1:0] mdio_rdata,
    output logic              addr_valid,
    output logic [1:0]        res_mode,
    output logic              link_up,
    output logic              link_fail,
    output logic              res_upd,
    output logic              link_down_evt
);
    localparam int MAXT  = (POLL_TICKS > LINK_TO_TICKS) ? POLL_TICKS : LINK_TO_TICKS;
    localparam int CNT_W = $clog2(MAXT + 1);

    mgr_state_e        state;
    logic              active;
    logic              xfer_done;
    logic              link_bit;
    logic              an_path;
    logic [1:0]        forced_mode;
    logic [ABIL_W-1:0] adv_q;
    logic              tmr_clr;
    logic              tmr_exp;
    logic              timer_done;
    logic [CNT_W-1:0]  tmr_limit;
    logic              is_txn;
    mdio_cmd_t         cmd_c;
    link_res_t         res_q;
    link_res_t         res_nx;
    logic              res_set;
    logic              rs_ok;
    logic [1:0]        rs_mode;
    logic              unused_rdata_bits;

    assign active     = auto_sel_en && !sw_override;
    assign xfer_done  = mdio_req && mdio_ack;
    assign link_bit   = mdio_rdata[STAT_LINK];
    assign timer_done = tmr_exp && !tmr_clr;
    assign unused_rdata_bits = ^{mdio_rdata[DATA_W-1:ABIL_HI+1], mdio_rdata[4],
                                 mdio_rdata[1:0]};

    assign res_mode  = res_q.mode;
    assign link_up   = res_q.up;
    assign link_fail = res_q.fail;

    ppm_addr_shadow #(.AW(ADDR_W)) u_shadow (
        .clk       (clk),
        .rst       (rst),
        .load_done (cfg_load_done),
        .addr_in   (cfg_phy_addr),
        .addr_q    (mdio_phy),
        .valid     (addr_valid)
    );

    assign tmr_limit = (state == S_LNK_A || state == S_LNK_B) ?
                       CNT_W'(LINK_TO_TICKS) : CNT_W'(POLL_TICKS);

    ppm_tick_timer #(.TICK_DIV(TICK_DIV), .CNT_W(CNT_W)) u_timer (
        .clk     (clk),
        .rst     (rst),
        .clr     (tmr_clr),
        .limit   (tmr_limit),
        .expired (tmr_exp)
    );

    ppm_resolver u_resolve (
        .adv_abil (adv_q),
        .lpa_abil (mdio_rdata[ABIL_HI:ABIL_LO]),
        .ok       (rs_ok),
        .mode     (rs_mode)
    );

    // Command belonging to each transaction state
    always_comb begin
        is_txn = 1'b1;
        cmd_c  = '{wr: 1'b0, regad: REG_STAT, wdata: '0};
        case (state)
            S_ST_A, S_ST_B, S_LNK_A, S_LNK_B, S_MON_A, S_MON_B: ;
            S_WR_CTRL: cmd_c = '{wr: 1'b1, regad: REG_CTRL,
                                 wdata: ctrl_word(an_path, forced_mode[1], forced_mode[0])};
            S_RD_ADV:  cmd_c.regad = REG_ADV;
            S_RD_LPA:  cmd_c.regad = REG_LPA;
            default:   is_txn = 1'b0;
        endcase
    end

    // Result produced by a completed transaction
    always_comb begin
        res_set = 1'b0;
        res_nx  = res_q;
        if (xfer_done) begin
            case (state)
                S_LNK_B: begin
                    if (link_bit && !an_path) begin
                        res_set = 1'b1;
                        res_nx  = '{up: 1'b1, fail: 1'b0, mode: forced_mode};
                    end else if (!link_bit && timer_done) begin
                        res_set = 1'b1;
                        res_nx  = '{up: 1'b0, fail: 1'b1, mode: 2'b00};
                    end
                end
                S_RD_LPA: begin
                    res_set = 1'b1;
                    res_nx  = rs_ok ? '{up: 1'b1, fail: 1'b0, mode: rs_mode}
                                    : '{up: 1'b0, fail: 1'b1, mode: 2'b00};
                end
                S_MON_B: begin
                    if (!link_bit) begin
                        res_set = 1'b1;
                        res_nx  = '{up: 1'b0, fail: 1'b0, mode: 2'b00};
                    end
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state         <= S_IDLE;
            mdio_req      <= 1'b0;
            mdio_wr       <= 1'b0;
            mdio_reg      <= '0;
            mdio_wdata    <= '0;
            an_path       <= 1'b0;
            forced_mode   <= 2'b00;
            adv_q         <= '0;
            tmr_clr       <= 1'b0;
            res_q         <= '0;
            res_upd       <= 1'b0;
            link_down_evt <= 1'b0;
        end else begin
            tmr_clr       <= 1'b0;
            res_upd       <= 1'b0;
            link_down_evt <= 1'b0;
            if (res_set) begin
                res_q   <= res_nx;
                res_upd <= (res_nx != res_q);
            end
            if (!active && !mdio_req) begin
                state <= S_IDLE;
            end else if (is_txn && !mdio_req) begin
                mdio_req   <= 1'b1;
                mdio_wr    <= cmd_c.wr;
                mdio_reg   <= cmd_c.regad;
                mdio_wdata <= cmd_c.wdata;
            end else begin
                if (xfer_done) mdio_req <= 1'b0;
                case (state)
                    S_IDLE:
                        if (active && phy_present && addr_valid) state <= S_ST_A;
                    S_ST_A:
                        if (xfer_done) state <= S_ST_B;
                    S_ST_B:
                        if (xfer_done) begin
                            an_path     <= mdio_rdata[STAT_ANABLE] && force_an_en;
                            forced_mode <= {force_100, force_fdx};
                            state       <= S_WR_CTRL;
                        end
                    S_WR_CTRL:
                        if (xfer_done) begin
                            tmr_clr <= 1'b1;
                            state   <= S_LNK_A;
                        end
                    S_LNK_A:
                        if (xfer_done) state <= S_LNK_B;
                    S_LNK_B:
                        if (xfer_done) begin
                            if (link_bit) begin
                                if (an_path) begin
                                    state <= S_RD_ADV;
                                end else begin
                                    tmr_clr <= 1'b1;
                                    state   <= S_MON_WAIT;
                                end
                            end else if (timer_done) begin
                                tmr_clr <= 1'b1;
                                state   <= S_FAIL_WAIT;
                            end else begin
                                state <= S_LNK_A;
                            end
                        end
                    S_RD_ADV:
                        if (xfer_done) begin
                            adv_q <= mdio_rdata[ABIL_HI:ABIL_LO];
                            state <= S_RD_LPA;
                        end
                    S_RD_LPA:
                        if (xfer_done) begin
                            tmr_clr <= 1'b1;
                            state   <= rs_ok ? S_MON_WAIT : S_FAIL_WAIT;
                        end
                    S_MON_WAIT:
                        if (timer_done) state <= S_MON_A;
                    S_MON_A:
                        if (xfer_done) state <= S_MON_B;
                    S_MON_B:
                        if (xfer_done) begin
                            if (link_bit) begin
                                tmr_clr <= 1'b1;
                                state   <= S_MON_WAIT;
                            end else begin
                                link_down_evt <= 1'b1;
                                state         <= S_ST_A;
                            end
                        end
                    S_FAIL_WAIT:
                        if (timer_done) state <= S_ST_A;
                    default:
                        state <= S_IDLE;
                endcase
            end
        end
    end
endmodule

// File: rtl/ppm_checker.sv
module ppm_checker (
    input logic        clk,
    input logic        rst,
    input logic        auto_sel_en,
    input logic        sw_override,
    input logic        mdio_req,
    input logic        mdio_ack,
    input logic        mdio_wr,
    input logic [4:0]  mdio_phy,
    input logic [4:0]  mdio_reg,
    input logic [15:0] mdio_wdata,
    input logic        addr_valid,
    input logic [1:0]  res_mode,
    input logic        link_up,
    input logic        link_fail,
    input logic        res_upd,
    input logic        link_down_evt
);
    AST_QUIET_WHEN_OFF: assert property (@(posedge clk) disable iff (rst)
        ((!auto_sel_en || sw_override) && !mdio_req) |=> !mdio_req); // R1
    AST_REQ_HAS_ADDR: assert property (@(posedge clk) disable iff (rst)
        mdio_req |-> addr_valid); // R3
    AST_ADDR_FROZEN: assert property (@(posedge clk) disable iff (rst)
        addr_valid |=> (addr_valid && $stable(mdio_phy))); // R3
    AST_REQ_HOLD: assert property (@(posedge clk) disable iff (rst)
        (mdio_req && !mdio_ack) |=> (mdio_req && $stable(mdio_wr) &&
                                     $stable(mdio_reg) && $stable(mdio_wdata))); // R4
    AST_WRITE_CTRL_ONLY: assert property (@(posedge clk) disable iff (rst)
        (mdio_req && mdio_wr) |-> (mdio_reg == 5'd0)); // R12
    AST_UP_FAIL_EXCL: assert property (@(posedge clk) disable iff (rst)
        !(link_up && link_fail)); // R11
    AST_DOWN_CLEARS: assert property (@(posedge clk) disable iff (rst)
        link_down_evt |-> (!link_up && !link_fail && res_upd)); // R10
    AST_UPD_ON_CHANGE: assert property (@(posedge clk) disable iff (rst)
        res_upd |-> ({link_up, link_fail, res_mode} !=
                     $past({link_up, link_fail, res_mode}))); // R11
endmodule

bind phy_port_mgr ppm_checker u_chk (.*);

// File: tb/test_phy_port_mgr.sv
module test_phy_port_mgr;
    import ppm_pkg::*;

    localparam int CLK_PERIOD = 10;
    localparam int TICK = 4;
    localparam int POLL = 10;
    localparam int LTO  = 25;

    logic clk = 1'b0;
    logic rst;
    logic auto_sel_en, sw_override, phy_present, cfg_load_done;
    logic [4:0] cfg_phy_addr;
    logic force_an_en, force_100, force_fdx;
    logic mdio_req, mdio_wr, mdio_ack;
    logic [4:0] mdio_phy, mdio_reg;
    logic [15:0] mdio_wdata, mdio_rdata;
    logic addr_valid, link_up, link_fail, res_upd, link_down_evt;
    logic [1:0] res_mode;

    always #(CLK_PERIOD/2) clk = ~clk;

    int cyc = 0;
    always @(posedge clk) cyc <= cyc + 1;

    phy_port_mgr #(.TICK_DIV(TICK), .POLL_TICKS(POLL), .LINK_TO_TICKS(LTO)) i_phy_port_mgr (
        .clk(clk), .rst(rst), .auto_sel_en(auto_sel_en), .sw_override(sw_override),
        .phy_present(phy_present), .cfg_load_done(cfg_load_done),
        .cfg_phy_addr(cfg_phy_addr), .force_an_en(force_an_en), .force_100(force_100),
        .force_fdx(force_fdx), .mdio_req(mdio_req), .mdio_wr(mdio_wr),
        .mdio_phy(mdio_phy), .mdio_reg(mdio_reg), .mdio_wdata(mdio_wdata),
        .mdio_ack(mdio_ack), .mdio_rdata(mdio_rdata), .addr_valid(addr_valid),
        .res_mode(res_mode), .link_up(link_up), .link_fail(link_fail),
        .res_upd(res_upd), .link_down_evt(link_down_evt)
    );

    int checks = 0;
    int errors = 0;

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    // PHY model: status link bit latches low until read
    logic phy_link = 1'b0;
    logic ll = 1'b0;
    logic an_able = 1'b1;
    logic [15:0] adv = 16'h01E1;
    logic [15:0] lpa = 16'h0061;
    logic [15:0] last_ctrl = 16'h0;
    int n_req = 0, n_stat = 0, bad_addr = 0, bad_wr = 0, ctrl_cyc = 0;

    initial begin
        mdio_ack   = 1'b0;
        mdio_rdata = 16'h0;
        forever begin
            @(negedge clk);
            if (mdio_ack) begin
                mdio_ack = 1'b0;
            end else if (mdio_req) begin
                mdio_ack = 1'b1;
                n_req++;
                if (mdio_phy != 5'h0A) bad_addr++;
                if (mdio_wr) begin
                    if (mdio_reg != 5'd0) bad_wr++;
                    else begin
                        last_ctrl = mdio_wdata;
                        ctrl_cyc  = cyc;
                    end
                    mdio_rdata = 16'h0;
                end else begin
                    case (mdio_reg)
                        5'd1: begin
                            mdio_rdata = {12'h0, an_able, (phy_link && !ll), 2'b00};
                            ll = 1'b0;
                            n_stat++;
                        end
                        5'd4:    mdio_rdata = adv;
                        5'd5:    mdio_rdata = lpa;
                        default: mdio_rdata = 16'h0;
                    endcase
                end
            end
        end
    end

    // Scoreboard
    link_res_t expq[$];
    string     tagq[$];
    int down_cnt = 0;
    int fail_cyc = 0;

    task automatic expect_res(input logic up, input logic fail, input logic [1:0] mode,
                              input string tag);
        expq.push_back('{up: up, fail: fail, mode: mode});
        tagq.push_back(tag);
    endtask

    initial begin
        forever begin
            @(negedge clk);
            if (link_down_evt) down_cnt++;
            if (res_upd) begin
                link_res_t got;
                got = '{up: link_up, fail: link_fail, mode: res_mode};
                if (link_fail) fail_cyc = cyc;
                if (expq.size() == 0) begin
                    check(1'b0, "R11 unexpected update", int'(got), 0);
                end else begin
                    link_res_t e;
                    string t;
                    e = expq.pop_front();
                    t = tagq.pop_front();
                    check(got == e, t, int'(got), int'(e));
                end
            end
        end
    end

    task automatic wait_drain(input int max, input string tag);
        for (int i = 0; i < max && expq.size() != 0; i++) @(negedge clk);
        check(expq.size() == 0, tag, expq.size(), 0);
    endtask

    task automatic bounce_link();
        int d0;
        d0 = down_cnt;
        phy_link = 1'b0;
        for (int i = 0; i < 400 && down_cnt == d0; i++) @(negedge clk);
        phy_link = 1'b1;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        int s0, n0, dt;
        rst = 1'b1;
        auto_sel_en = 1'b0; sw_override = 1'b0; phy_present = 1'b1;
        cfg_load_done = 1'b0; cfg_phy_addr = 5'h0A;
        force_an_en = 1'b1; force_100 = 1'b0; force_fdx = 1'b0;
        repeat (3) @(posedge clk);
        @(negedge clk) rst = 1'b0;

        check({link_up, link_fail, res_mode} == 4'b0, "R11 reset result",
              {link_up, link_fail, res_mode}, 0);
        check(!mdio_req && !addr_valid, "R3 reset idle", {mdio_req, addr_valid}, 0);

        auto_sel_en = 1'b1;
        repeat (50) @(negedge clk);
        check(n_req == 0, "R2 no address captured", n_req, 0);

        auto_sel_en = 1'b0;
        cfg_load_done = 1'b1;
        @(negedge clk);
        cfg_load_done = 1'b0;
        cfg_phy_addr = 5'h15;
        check(addr_valid == 1'b1, "R3 capture", addr_valid, 1);
        repeat (100) @(negedge clk);
        check(n_req == 0, "R1 inactive quiet", n_req, 0);

        phy_present = 1'b0;
        auto_sel_en = 1'b1;
        repeat (60) @(negedge clk);
        check(n_req == 0, "R2 no PHY present", n_req, 0);

        // 10 full chosen over 10 half
        phy_link = 1'b1;
        expect_res(1'b1, 1'b0, 2'b01, "R6 10 full");
        phy_present = 1'b1;
        wait_drain(500, "R6 drain");

        s0 = n_stat;
        repeat (400) @(negedge clk);
        check((n_stat - s0) >= 14 && (n_stat - s0) <= 20, "R9 poll rate", n_stat - s0, 17);

        ll = 1'b1;
        repeat (120) @(negedge clk);
        check(down_cnt == 0 && link_up, "R4 second status read used", down_cnt, 0);

        // 100 full has top priority
        lpa = 16'h03E1;
        expect_res(1'b0, 1'b0, 2'b00, "R10 down");
        expect_res(1'b1, 1'b0, 2'b11, "R6 100 full");
        bounce_link();
        wait_drain(500, "R6 drain");
        check(down_cnt == 1, "R10 down event", down_cnt, 1);

        // T4 over 100 half
        adv = 16'h0281; lpa = 16'h0381;
        expect_res(1'b0, 1'b0, 2'b00, "R10 down");
        expect_res(1'b1, 1'b0, 2'b10, "R6 T4");
        bounce_link();
        wait_drain(500, "R6 drain");

        // no common ability
        adv = 16'h0021; lpa = 16'h0041;
        expect_res(1'b0, 1'b0, 2'b00, "R10 down");
        expect_res(1'b0, 1'b1, 2'b00, "R7 no common mode");
        bounce_link();
        wait_drain(500, "R7 drain");
        repeat (200) @(negedge clk);
        check(link_fail && !link_up, "R7 stays failed", {link_up, link_fail}, 1);

        // forced because PHY cannot negotiate
        an_able = 1'b0; force_100 = 1'b1; force_fdx = 1'b0;
        expect_res(1'b1, 1'b0, 2'b10, "R5 forced 100 half");
        wait_drain(600, "R5 drain");
        check(last_ctrl == 16'h2000, "R5 control word", last_ctrl, 16'h2000);

        // forced because negotiation disallowed
        an_able = 1'b1; force_an_en = 1'b0; force_100 = 1'b0; force_fdx = 1'b1;
        expect_res(1'b0, 1'b0, 2'b00, "R10 down");
        expect_res(1'b1, 1'b0, 2'b01, "R5 forced 10 full");
        bounce_link();
        wait_drain(500, "R5 drain");
        check(last_ctrl == 16'h0100, "R5 control word", last_ctrl, 16'h0100);

        // timeout
        expect_res(1'b0, 1'b0, 2'b00, "R10 down");
        expect_res(1'b0, 1'b1, 2'b00, "R8 timeout");
        phy_link = 1'b0;
        wait_drain(800, "R8 drain");
        dt = fail_cyc - ctrl_cyc;
        check(dt >= LTO*TICK && dt <= LTO*TICK + 16, "R8 timeout length", dt, LTO*TICK);

        sw_override = 1'b1;
        repeat (20) @(negedge clk);
        n0 = n_req;
        repeat (300) @(negedge clk);
        check(n_req == n0, "R1 override quiet", n_req - n0, 0);

        check(bad_wr == 0, "R12 writes only control", bad_wr, 0);
        check(bad_addr == 0, "R3 shadow address used", bad_addr, 0);
        check(expq.size() == 0, "R11 no pending", expq.size(), 0);
        finish_run();
    end
endmodule